// File: doc/BRIEF.md
# Dual-Precision SAR Conversion Controller

This block sequences a charge-redistribution successive-approximation converter. A start request launches a conversion. The block then tests one result bit per clock, from the most significant bit down. For each bit it raises the trial bit on the capacitor-switch code, samples the external comparator on the next rising edge, and keeps or drops the bit. Once the last bit is resolved, the finished word is copied into a result register and the busy indication falls.

A mode input chooses between the full 11-step conversion and a quicker 6-step one. The mode is captured when the conversion starts. The busy output stays high from the start edge until the result is valid, so a system can drive start and watch busy on one shared line. The sampling switch, the capacitor array and the comparator live outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high reset, including one applied during a conversion, sets `busy_o`, `dac_code_o` and `result_o` to zero on the next rising edge.
- R2: When `start_i` is high at a rising edge and `busy_o` is low, `busy_o` is high after that edge and `dac_code_o` equals 11'h400, which is the MSB trial alone.
- R3: With `mode_short_i` low at the start edge, `busy_o` stays high for exactly 11 clock cycles.
- R4: With `mode_short_i` high at the start edge, `busy_o` stays high for exactly 6 clock cycles, and bits 4 down to 0 of the result are zero.
- R5: Each step samples `cmp_i` at the rising edge. `cmp_i` high means the input is at or above the trial level, and the bit under test is then kept; low clears it. At the same edge the next lower bit is raised as the new trial. Exactly one bit is under test at any time during a conversion.
- R6: A `start_i` pulse while `busy_o` is high, including at the edge that completes a conversion, has no effect on the step count or the result, and does not start a new conversion.
- R7: A change of `mode_short_i` during a conversion has no effect on that conversion's length or result.
- R8: `result_o` is updated only at the edge that ends a conversion. It holds its previous value while busy and between conversions.
- R9: `result_o` bit 10 holds the MSB decision and bit 0 holds the LSB. For an ideal comparator and input value V, the 11-bit result equals V, and the 6-bit result equals V with bits 4:0 cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only while idle |
| mode_short_i | input | 1 | 1 selects the 6-step conversion, 0 the 11-step one |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| busy_o | output | 1 | High from the start edge until the result is valid |
| dac_code_o | output | 11 | Capacitor-switch trial code |
| result_o | output | 11 | Last completed conversion, MSB at bit 10 |

## Verification
Two events can coincide: a start request and the completion of the running conversion, or a start request and any middle step. The bench raises `start_i` exactly on the final step of a conversion, and also in the middle of one. It then checks that busy falls after the expected number of cycles, that it stays low on the following cycle, and that the result matches the value expected from the applied input. A mode flip in the middle of a conversion is also applied. The conversion length and result are judged against the mode that was present at the start edge.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned RES_W   = 11;
  localparam int unsigned SHORT_W = 6;

  // number of approximation steps for the chosen mode
  function automatic int unsigned steps_for(input logic short_mode,
                                            input int unsigned full_w,
                                            input int unsigned short_w);
    return short_mode ? short_w : full_w;
  endfunction

  // bit index resolved on the final step of a conversion
  function automatic int unsigned last_index(input logic short_mode,
                                             input int unsigned full_w,
                                             input int unsigned short_w);
    return full_w - steps_for(short_mode, full_w, short_w);
  endfunction

endpackage

// File: rtl/sar_bit_ptr.sv
module sar_bit_ptr #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic         advance,
  input  logic         clear,
  output logic [W-1:0] ptr_o
);

  localparam logic [W-1:0] TOP_ONE = {1'b1, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o <= '0;
    end else if (launch) begin
      ptr_o <= TOP_ONE;
    end else if (advance) begin
      ptr_o <= ptr_o >> 1;
    end else if (clear) begin
      ptr_o <= '0;
    end
  end

endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic         step_en,
  input  logic         last,
  input  logic [W-1:0] ptr,
  input  logic         cmp,
  output logic [W-1:0] code_o,
  output logic [W-1:0] code_nxt_o
);

  localparam logic [W-1:0] TOP_ONE = {1'b1, {(W-1){1'b0}}};

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == W - 1) begin : g_top
      always_comb begin
        if (step_en && ptr[i]) code_nxt_o[i] = cmp;
        else                   code_nxt_o[i] = code_o[i];
      end
    end else begin : g_low
      always_comb begin
        if (!step_en)                 code_nxt_o[i] = code_o[i];
        else if (ptr[i])              code_nxt_o[i] = cmp;
        else if (ptr[i+1] && !last)   code_nxt_o[i] = 1'b1;
        else                          code_nxt_o[i] = code_o[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         code_o <= '0;
    else if (launch) code_o <= TOP_ONE;
    else             code_o <= code_nxt_o;
  end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned FULL_W  = sar_pkg::RES_W,
  parameter int unsigned SHORT_W = sar_pkg::SHORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              mode_short_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic [FULL_W-1:0] dac_code_o,
  output logic [FULL_W-1:0] result_o
);

  localparam int unsigned LAST_SHORT = sar_pkg::last_index(1'b1, FULL_W, SHORT_W);
  localparam int unsigned LAST_FULL  = sar_pkg::last_index(1'b0, FULL_W, SHORT_W);

  logic              busy_q;
  logic              mode_q;
  logic [FULL_W-1:0] ptr;
  logic [FULL_W-1:0] code_nxt;
  logic              step_last;
  logic              launch;
  logic              advance;
  logic              finish;

  // named events for the checker
  assign launch    = start_i & ~busy_q;
  assign step_last = mode_q ? ptr[LAST_SHORT] : ptr[LAST_FULL];
  assign finish    = busy_q & step_last;
  assign advance   = busy_q & ~step_last;

  sar_bit_ptr #(.W(FULL_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .advance (advance),
    .clear   (finish),
    .ptr_o   (ptr)
  );

  sar_code_reg #(.W(FULL_W)) u_code (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .step_en    (busy_q),
    .last       (step_last),
    .ptr        (ptr),
    .cmp        (cmp_i),
    .code_o     (dac_code_o),
    .code_nxt_o (code_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      mode_q   <= 1'b0;
      result_o <= '0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      mode_q   <= mode_short_i;
    end else if (finish) begin
      busy_q   <= 1'b0;
      result_o <= code_nxt;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int unsigned W       = 11,
  parameter int unsigned SHORT_W = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic         busy_o,
  input logic         mode_q,
  input logic         step_last,
  input logic [W-1:0] ptr,
  input logic [W-1:0] dac_code_o,
  input logic [W-1:0] result_o
);

  localparam int unsigned LOW_W = W - SHORT_W;
  localparam logic [W-1:0] TOP_ONE = {1'b1, {(W-1){1'b0}}};

  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) run_cnt <= 0;
    else                run_cnt <= run_cnt + 1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy_o && dac_code_o == '0 && result_o == '0));

  // R2
  launch_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && dac_code_o == TOP_ONE));

  // R3
  step_count_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && step_last) |->
      (run_cnt + 1 == sar_pkg::steps_for(mode_q, W, SHORT_W)));

  // R4
  short_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && mode_q) |-> (result_o[LOW_W-1:0] == '0));

  // R5
  single_trial_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> ($countones(ptr) == 1));

  // R6
  no_early_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !step_last) |=> busy_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && step_last) |=> $stable(result_o));

endmodule

bind sar_conv_ctrl sar_conv_chk #(.W(FULL_W), .SHORT_W(SHORT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .mode_q     (mode_q),
  .step_last  (step_last),
  .ptr        (ptr),
  .dac_code_o (dac_code_o),
  .result_o   (result_o)
);

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic        mode_short_i;
  logic        cmp_i;
  logic        busy_o;
  logic [10:0] dac_code_o;
  logic [10:0] result_o;

  logic [10:0] vin;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  sar_conv_ctrl dut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .mode_short_i (mode_short_i),
    .cmp_i        (cmp_i),
    .busy_o       (busy_o),
    .dac_code_o   (dac_code_o),
    .result_o     (result_o)
  );

  // ideal comparator model
  always_comb cmp_i = (vin >= dac_code_o);

  function automatic logic [10:0] want_result(input logic [10:0] v, input logic short_m);
    return short_m ? {v[10:5], 5'b00000} : v;
  endfunction

  function automatic int want_steps(input logic short_m);
    return short_m ? 6 : 11;
  endfunction

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic run_conv(input logic [10:0] v, input logic short_m,
                          input bit poke_start, input bit flip_mode);
    logic [10:0] prev_res;
    int          n;
    bit          held;
    int          steps;
    steps    = want_steps(short_m);
    prev_res = result_o;
    held     = 1'b1;
    n        = 0;
    vin          = v;
    start_i      = 1'b1;
    mode_short_i = short_m;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1 && dac_code_o == 11'h400, "R2", int'(dac_code_o), 11'h400);
    while (busy_o && n < 40) begin
      n++;
      if (result_o != prev_res) held = 1'b0;
      start_i = poke_start && (n == 2 || n == steps);
      if (flip_mode && n == 2) mode_short_i = ~short_m;
      @(negedge clk);
    end
    start_i = 1'b0;
    check(n == steps, short_m ? "R4" : "R3", n, steps);
    check(held, "R8", int'(result_o), int'(prev_res));
    check(result_o == want_result(v, short_m), poke_start ? "R6" : (flip_mode ? "R7" : "R9"),
          int'(result_o), int'(want_result(v, short_m)));
    if (short_m) check(result_o[4:0] == 5'd0, "R4", int'(result_o[4:0]), 0);
    @(negedge clk);
    check(busy_o == 1'b0, "R6", int'(busy_o), 0);
    mode_short_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; start_i = 1'b0; mode_short_i = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    check(busy_o == 0 && dac_code_o == 0 && result_o == 0, "R1", int'(result_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // directed corners
    run_conv(11'h000, 1'b0, 1'b0, 1'b0);
    run_conv(11'h7FF, 1'b0, 1'b0, 1'b0);
    run_conv(11'h400, 1'b0, 1'b0, 1'b0);
    run_conv(11'h3FF, 1'b0, 1'b0, 1'b0);
    run_conv(11'h7FF, 1'b1, 1'b0, 1'b0);
    run_conv(11'h41F, 1'b1, 1'b0, 1'b0);
    run_conv(11'h555, 1'b0, 1'b1, 1'b0);   // start during and at completion
    run_conv(11'h2AA, 1'b1, 1'b1, 1'b0);
    run_conv(11'h6B3, 1'b1, 1'b0, 1'b1);   // R7 mode flip mid-run
    run_conv(11'h19C, 1'b0, 1'b0, 1'b1);

    // R5: trial code after the first decision with comparator low and high
    vin = 11'h100; start_i = 1'b1; mode_short_i = 1'b0;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check(dac_code_o == 11'h200, "R5", int'(dac_code_o), 11'h200);
    repeat (12) @(negedge clk);
    vin = 11'h600; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check(dac_code_o == 11'h600, "R5", int'(dac_code_o), 11'h600);

    // R1: reset in mid conversion
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy_o == 0 && dac_code_o == 0 && result_o == 0, "R1", int'(dac_code_o), 0);
    @(negedge clk);

    // constrained random
    for (int k = 0; k < 60; k++) begin
      run_conv(11'($urandom % 2048), 1'($urandom % 2), 1'($urandom % 4 == 0),
               1'($urandom % 4 == 0));
    end

    finish_run();
  end

endmodule